// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises an interrupt request when any of eight port input levels departs from a stored reference image of the port. The pins are first brought into the clock domain by a short synchroniser chain. The synchronised value is then compared bit by bit against the reference image. The comparison result is registered before it drives the request output, so the output cannot glitch. The output is active high and means "pull the open-drain interrupt pad low". The pad itself sits outside this block.

The bus logic sends a one-cycle strobe when it completes a read of the port and another when it completes a write to the port. Either strobe captures the current synchronised pin value as the new reference and forces the request inactive for that cycle. When the pins move back to the reference value, the request drops again without any bus access. After reset the reference holds all ones. Any pin that is held low from outside therefore raises a request as soon as reset is released.

Top module: `port_change_irq`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the reference image and every synchroniser stage load all ones, and `irq_pull_o` is 0 from the following edge onward.
- R2: If a pin is held low across the release of reset, `irq_pull_o` rises at the third rising clock edge after the first edge that sees `rst_ni` high.
- R3: A change of any pin in either direction that leaves the synchronised value different from the reference sets `irq_pull_o` exactly SYNC_STAGES+1 (3 by default) edges after the change. The output is taken straight from a flop.
- R4: Once the pins return to the reference value, `irq_pull_o` clears by itself with the same SYNC_STAGES+1 edge latency.
- R5: An edge with `rd_done_i` high drives `irq_pull_o` to 0 at that edge and loads the synchronised pin value into the reference.
- R6: An edge with `wr_done_i` high has the same clearing and reference-loading effect as a read strobe.
- R7: After a clear, a later pin change is compared with the new reference and raises `irq_pull_o` again with the R3 latency. Pins that stay equal to the new reference keep it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pins_i | input | 8 | Raw port pin levels, asynchronous |
| rd_done_i | input | 1 | One-cycle strobe: a port read has completed |
| wr_done_i | input | 1 | One-cycle strobe: a port write has completed |
| irq_pull_o | output | 1 | 1 = drive the open-drain interrupt pad low |

## Verification
The bench goes through all 256 pin patterns. For each pattern it checks that the request holds off for two edges and appears on the third. This catches a design with one synchroniser stage too few or too many. It also checks that read and write strobes both clear the request on the strobe edge. A design that cleared on only one strobe kind, or failed to load the reference, would re-raise the request one edge later. For every pattern, a single flipped bit must set the request and restoring that bit must clear it. This exposes a design that latches edges instead of comparing levels, because such a design would never clear by itself. Reset is released with pins held low, to prove the reference starts at all ones and not at zeros.

// File: rtl/port_change_irq_pkg.sv
// Shared defaults for the port change interrupt generator.
package port_change_irq_pkg;
    parameter int unsigned PIN_W_DEF = 8;
    parameter int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/pci_sync.sv
// Multi-stage synchroniser for the raw pin levels.
// Assumes: pins are asynchronous and static levels; each stage resets to ones
// so idle-high pins do not look like a change after reset.
module pci_sync #(
    parameter int unsigned PIN_W  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PIN_W-1:0] raw_i,
    output logic [PIN_W-1:0] sync_o
);
    logic [PIN_W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage captures the asynchronous pins
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stage_q[s] <= '1;
                else         stage_q[s] <= raw_i;
            end
        end else begin : g_next
            // later stages pass the value along the chain
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stage_q[s] <= '1;
                else         stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pci_snapshot.sv
// Reference image of the port, captured on a completed read or write.
// Assumes: strobes are one cycle wide and synchronous to clk_i.
module pci_snapshot #(
    parameter int unsigned PIN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [PIN_W-1:0] sync_i,
    output logic [PIN_W-1:0] snap_o
);
    logic [PIN_W-1:0] snap_q;

    // hold the reference; reload it from the synchronised pins on a strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     snap_q <= '1;
        else if (load_i) snap_q <= sync_i;
    end

    assign snap_o = snap_q;
endmodule

// File: rtl/pci_irq_reg.sv
// Level comparison of the pins against the reference, with a registered output.
// Assumes: clear_i coincides with the reference reload, so a forced-inactive
// cycle covers the window in which the reference is updated.
module pci_irq_reg #(
    parameter int unsigned PIN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic [PIN_W-1:0] sync_i,
    input  logic [PIN_W-1:0] snap_i,
    output logic             irq_o
);
    logic differ;
    logic irq_q;

    // any bit that disagrees with the reference is a pending change
    always_comb differ = |(sync_i ^ snap_i);

    // register the request so the pad driver never sees a glitch
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      irq_q <= 1'b0;
        else if (clear_i) irq_q <= 1'b0;
        else              irq_q <= differ;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/port_change_irq.sv
// Top: synchroniser, reference image and registered comparison.
// Assumes: rd_done_i / wr_done_i come from the bus logic in the clk_i domain.
module port_change_irq
    import port_change_irq_pkg::*;
#(
    parameter int unsigned PIN_W       = PIN_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             rd_done_i,
    input  logic             wr_done_i,
    output logic             irq_pull_o
);
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] snap_q;
    logic             access;

    // either completed access refreshes the reference and clears the request
    always_comb access = rd_done_i | wr_done_i;

    pci_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (pins_i),
        .sync_o (pin_sync)
    );

    pci_snapshot #(.PIN_W(PIN_W)) u_snap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (access),
        .sync_i (pin_sync),
        .snap_o (snap_q)
    );

    pci_irq_reg #(.PIN_W(PIN_W)) u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (access),
        .sync_i  (pin_sync),
        .snap_i  (snap_q),
        .irq_o   (irq_pull_o)
    );
endmodule

// File: rtl/port_change_irq_chk.sv
// Checker for port_change_irq, bound to every instance of the top.
module port_change_irq_chk #(
    parameter int unsigned PIN_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rd_done_i,
    input logic             wr_done_i,
    input logic [PIN_W-1:0] pin_sync,
    input logic [PIN_W-1:0] snap_q,
    input logic             irq_pull_o
);
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_done_i |=> !irq_pull_o);

    a_r6_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_done_i |=> !irq_pull_o);

    a_r5_snap_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_done_i || wr_done_i) |=> (snap_q == $past(pin_sync)));

    a_r7_snap_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_done_i || wr_done_i) |=> $stable(snap_q));

    a_r3_mismatch_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_done_i && !wr_done_i && (pin_sync != snap_q)) |=> irq_pull_o);

    a_r4_match_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_sync == snap_q) |=> !irq_pull_o);
endmodule

bind port_change_irq port_change_irq_chk #(.PIN_W(PIN_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_done_i  (rd_done_i),
    .wr_done_i  (wr_done_i),
    .pin_sync   (pin_sync),
    .snap_q     (snap_q),
    .irq_pull_o (irq_pull_o)
);

// File: tb/port_change_irq_tb_top.sv
// Self-checking bench: sweeps every pin pattern with a model of the reference.
module port_change_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'hFF;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [7:0] snap_m;

    always #4 clk = ~clk;

    port_change_irq dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pins_i     (pins),
        .rd_done_i  (rd),
        .wr_done_i  (wr),
        .irq_pull_o (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_pull_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset with idle-high pins, then pins low while still in reset
        tick(4);
        check(irq, 1'b0, "R1");
        pins = 8'h5A;
        tick(4);
        check(irq, 1'b0, "R1");
        // R2: release with pins low; request appears on the third edge
        rst_n = 1'b1;
        tick(2);
        check(irq, 1'b0, "R2");
        tick(1);
        check(irq, 1'b1, "R2");
        // R5: read strobe clears and captures 0x5A
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        check(irq, 1'b0, "R5");
        snap_m = 8'h5A;
        tick(1);
        check(irq, 1'b0, "R5");

        for (int v = 0; v < 256; v++) begin
            // R3: new pattern, latency of exactly three edges
            pins = 8'(v);
            tick(2);
            check(irq, 1'b0, "R3");
            tick(1);
            check(irq, (8'(v) != snap_m), "R3");
            // R5 / R6: alternate strobes; both clear and reload the reference
            if (v % 2 == 1) rd = 1'b1;
            else            wr = 1'b1;
            tick(1);
            rd = 1'b0;
            wr = 1'b0;
            check(irq, 1'b0, (v % 2 == 1) ? "R5" : "R6");
            snap_m = 8'(v);
            tick(1);
            check(irq, 1'b0, "R7");
            // R7: one flipped bit against the new reference raises again
            pins = 8'(v) ^ (8'h01 << (v % 8));
            tick(3);
            check(irq, 1'b1, "R7");
            // R4: restoring the bit clears without any access
            pins = 8'(v);
            tick(2);
            check(irq, 1'b1, "R4");
            tick(1);
            check(irq, 1'b0, "R4");
        end

        // R1: reset mid-run with pins high returns to the quiet state
        pins = 8'hFF;
        rst_n = 1'b0;
        tick(2);
        check(irq, 1'b0, "R1");
        rst_n = 1'b1;
        tick(4);
        check(irq, 1'b0, "R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule